// File: doc/BRIEF.md
# Short Loop Replay Detector

This block watches the stream of decoded instructions leaving the front end and spots short inner loops that the instruction queue can replay on its own. Each beat carries the instruction address, flags for branch, call and taken backward branch, and the branch target. A taken backward branch proposes a candidate loop. The candidate's start is the branch target and its end is the branch address. Each later iteration is measured against a set of size limits. Once the loop has run enough qualifying iterations in a row, the block raises `lock`.

While `lock` is high, the block presents the loop's start and end addresses. The front end then stops fetching and decoding, and the queue serves the iterations. The lock falls when the loop is left, when the closing branch falls through, when a flush arrives, or when an address is seen outside the locked range. Every output is registered, so it reflects the beat presented one clock earlier.

Top module: `loop_lock_detector`

## Requirements
- R1: After reset, `lock` is 0 and `loop_start` and `loop_end` are 0.
- R2: After a taken backward branch opens a candidate, `lock` rises one cycle after the 65th later closing branch that matches the candidate (same target and same address). It is still 0 after the 64th.
- R3: An iteration qualifies only if it holds at most 17 instructions, counting the closing branch. An iteration of 18 instructions drops the candidate, so the loop never locks.
- R4: An iteration that contains a beat flagged as a call drops the candidate.
- R5: An iteration may hold at most 4 branch beats, counting the closing branch. A fifth branch drops the candidate.
- R6: The body's span is counted in 16-byte blocks, as (end >> 4) − (start >> 4) + 1 on the instruction addresses. A span of 4 blocks qualifies and a span of 5 blocks drops the candidate.
- R7: While `lock` is 1, `loop_start` equals the candidate's branch target and `loop_end` equals its closing-branch address, and both hold steady. While `lock` is 0, both outputs are 0.
- R8: A taken backward branch whose target or address differs from the candidate replaces the candidate and restarts the iteration count from zero.
- R9: While locked, a beat at the loop end that is not a taken backward branch back to the loop start drops `lock` in the next cycle.
- R10: `flush` drops `lock` and any candidate in the next cycle. It wins over a closing branch presented in the same cycle, and counting restarts from the next taken backward branch.
- R11: While locked, a beat whose address is below the loop start or above the loop end drops `lock` in the next cycle.
- R12: While a candidate is being counted, a beat outside its address range abandons it, and counting restarts from the next taken backward branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction beat is present |
| in_pc | input | PCW | Address of the instruction |
| in_is_branch | input | 1 | Beat is a branch of any kind |
| in_is_call | input | 1 | Beat is a subroutine call |
| in_taken_back | input | 1 | Beat is a taken branch to a lower address |
| in_target | input | PCW | Branch target of the beat |
| flush | input | 1 | Pipeline flush; abandons all loop state |
| lock | output | 1 | Loop is locked and served from the queue |
| loop_start | output | PCW | First address of the locked loop, 0 when unlocked |
| loop_end | output | PCW | Address of the locked loop's closing branch, 0 when unlocked |

## Verification
The delicate collision is a flush that lands in the same cycle as the closing branch that would complete the 65th iteration. Locking and abandoning are then both asked for at the same clock edge. The bench builds a candidate up to 64 counted iterations, presents that 65th closing branch with `flush` high, and expects `lock` to stay 0. It then expects `lock` to stay 0 across the next two closings as well, which proves the count went back to zero rather than being frozen. A second collision puts a replacing backward branch in the middle of a count. The bench judges it by the lock arriving exactly 65 closings after the replacement.

// File: rtl/lld_pkg.sv
package lld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_LOCK  = 2'd2
  } lld_state_e;

  // Number of aligned blocks touched between two addresses, both inclusive.
  function automatic int unsigned block_span(input logic [63:0] lo,
                                             input logic [63:0] hi,
                                             input int unsigned  blk_bits);
    logic [63:0] diff;
    diff = (hi >> blk_bits) - (lo >> blk_bits);
    return 32'(diff) + 32'd1;
  endfunction

  // All limits an iteration must respect to keep its candidate alive.
  function automatic logic body_fits(input int unsigned insns,
                                     input int unsigned brs,
                                     input logic        call_seen,
                                     input int unsigned blocks,
                                     input int unsigned insn_lim_excl,
                                     input int unsigned br_max,
                                     input int unsigned blk_max);
    return (insns < insn_lim_excl) && (brs <= br_max) &&
           !call_seen && (blocks <= blk_max);
  endfunction

endpackage

// File: rtl/lld_body_meter.sv
module lld_body_meter #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          is_branch,
  input  logic          is_call,
  output logic [CW-1:0] insn_cnt,
  output logic [CW-1:0] br_cnt,
  output logic          call_seen
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      insn_cnt  <= '0;
      br_cnt    <= '0;
      call_seen <= 1'b0;
    end else if (step) begin
      if (insn_cnt != '1) insn_cnt <= insn_cnt + CW'(1);
      if (is_branch && br_cnt != '1) br_cnt <= br_cnt + CW'(1);
      if (is_call) call_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/lld_iter_count.sv
module lld_iter_count #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (inc && cnt != '1) cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/loop_lock_detector.sv
module loop_lock_detector
  import lld_pkg::*;
#(
  parameter int unsigned PCW        = 32,
  parameter int unsigned INSN_LIMIT = 18,
  parameter int unsigned MAX_BRS    = 4,
  parameter int unsigned MAX_BLOCKS = 4,
  parameter int unsigned BLOCK_BITS = 4,
  parameter int unsigned ITER_MIN   = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [PCW-1:0] in_pc,
  input  logic           in_is_branch,
  input  logic           in_is_call,
  input  logic           in_taken_back,
  input  logic [PCW-1:0] in_target,
  input  logic           flush,
  output logic           lock,
  output logic [PCW-1:0] loop_start,
  output logic [PCW-1:0] loop_end
);

  localparam int unsigned BW = $clog2(INSN_LIMIT + 1);
  localparam int unsigned IW = $clog2(ITER_MIN + 2);

  lld_state_e     state, state_n;
  logic [PCW-1:0] cand_start, cand_end;
  logic [BW-1:0]  insn_cnt, br_cnt;
  logic           call_seen;
  logic [IW-1:0]  iter_cnt;

  // Named events used by the FSM and by the bound checker.
  logic back_beat, cand_match, in_range, at_end;
  logic ev_open, ev_close, ev_close_ok, ev_lock, ev_track_drop, ev_lock_keep;
  logic body_ok;

  assign back_beat  = in_valid && in_taken_back;
  assign cand_match = (in_target == cand_start) && (in_pc == cand_end);
  assign in_range   = (in_pc >= cand_start) && (in_pc <= cand_end);
  assign at_end     = (in_pc == cand_end);

  assign body_ok = body_fits(32'(insn_cnt) + 32'd1, 32'(br_cnt) + 32'd1,
                             call_seen || in_is_call,
                             block_span(64'(cand_start), 64'(cand_end), BLOCK_BITS),
                             INSN_LIMIT, MAX_BRS, MAX_BLOCKS);

  assign ev_open  = back_beat && ((state == ST_IDLE) ||
                                  (state == ST_TRACK && !cand_match));
  assign ev_close = back_beat && (state == ST_TRACK) && cand_match;
  assign ev_close_ok = ev_close && body_ok;
  assign ev_lock  = ev_close_ok && (iter_cnt >= IW'(ITER_MIN));

  // A non-branching beat that leaves the range or falls through the end.
  assign ev_track_drop = (state == ST_TRACK) &&
                         ((ev_close && !body_ok) ||
                          (in_valid && !in_taken_back && (!in_range || at_end)));

  assign ev_lock_keep = !in_valid ||
                        (back_beat && cand_match) ||
                        (!in_taken_back && in_range && !at_end);

  always_comb begin
    state_n = state;
    if (flush) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (ev_open) state_n = ST_TRACK;
        ST_TRACK: begin
          if (ev_lock)            state_n = ST_LOCK;
          else if (ev_open)       state_n = ST_TRACK;
          else if (ev_track_drop) state_n = ST_IDLE;
        end
        ST_LOCK:  if (!ev_lock_keep) state_n = ST_IDLE;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cand_start <= '0;
      cand_end   <= '0;
    end else begin
      state <= state_n;
      if (ev_open && !flush) begin
        cand_start <= in_target;
        cand_end   <= in_pc;
      end
    end
  end

  lld_body_meter #(.CW(BW)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (flush || back_beat || state_n != ST_TRACK),
    .step      (in_valid && state == ST_TRACK),
    .is_branch (in_is_branch),
    .is_call   (in_is_call),
    .insn_cnt  (insn_cnt),
    .br_cnt    (br_cnt),
    .call_seen (call_seen)
  );

  lld_iter_count #(.CW(IW)) u_iter (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flush || ev_open || state_n == ST_IDLE),
    .inc   (ev_close_ok),
    .cnt   (iter_cnt)
  );

  assign lock       = (state == ST_LOCK);
  assign loop_start = lock ? cand_start : '0;
  assign loop_end   = lock ? cand_end   : '0;

endmodule

// File: rtl/lld_checker.sv
module lld_checker
  import lld_pkg::*;
#(
  parameter int unsigned PCW        = 32,
  parameter int unsigned MAX_BLOCKS = 4,
  parameter int unsigned BLOCK_BITS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [PCW-1:0] in_pc,
  input logic           in_taken_back,
  input logic [PCW-1:0] in_target,
  input logic           flush,
  input logic           lock,
  input logic [PCW-1:0] loop_start,
  input logic [PCW-1:0] loop_end,
  input logic           ev_close_ok
);

  a_r2_lock_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(ev_close_ok));

  a_r10_flush_releases: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lock);

  a_r9_fallthrough_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && in_valid && in_pc == loop_end &&
     !(in_taken_back && in_target == loop_start)) |=> !lock);

  a_r11_outside_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && in_valid && (in_pc < loop_start || in_pc > loop_end)) |=> !lock);

  a_r7_bounds_steady: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (!lock || ($stable(loop_start) && $stable(loop_end))));

  a_r6_span_at_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (block_span(64'(loop_start), 64'(loop_end), BLOCK_BITS) <= MAX_BLOCKS));

endmodule

bind loop_lock_detector lld_checker #(
  .PCW(PCW), .MAX_BLOCKS(MAX_BLOCKS), .BLOCK_BITS(BLOCK_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
  .in_taken_back(in_taken_back), .in_target(in_target), .flush(flush),
  .lock(lock), .loop_start(loop_start), .loop_end(loop_end),
  .ev_close_ok(ev_close_ok)
);

// File: tb/loop_lock_detector_test.sv
`timescale 1ns/1ps
module loop_lock_detector_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_pc = '0;
  logic        in_is_branch = 1'b0;
  logic        in_is_call = 1'b0;
  logic        in_taken_back = 1'b0;
  logic [31:0] in_target = '0;
  logic        flush = 1'b0;
  logic        lock;
  logic [31:0] loop_start, loop_end;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  loop_lock_detector uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
    .in_is_branch(in_is_branch), .in_is_call(in_is_call),
    .in_taken_back(in_taken_back), .in_target(in_target), .flush(flush),
    .lock(lock), .loop_start(loop_start), .loop_end(loop_end)
  );

  // Row fields: beats per iteration, address step, extra non-closing
  // branches, call position (255 = none), expected lock.
  localparam logic [39:0] ROWS [8] = '{
    {8'd17, 8'd2,    8'd0, 8'd255, 8'd1},  // R3 17 insns
    {8'd18, 8'd2,    8'd0, 8'd255, 8'd0},  // R3 18 insns
    {8'd5,  8'd2,    8'd3, 8'd255, 8'd1},  // R5 4 branches
    {8'd6,  8'd2,    8'd4, 8'd255, 8'd0},  // R5 5 branches
    {8'd5,  8'd2,    8'd0, 8'd255, 8'd1},  // R4 no call
    {8'd5,  8'd2,    8'd0, 8'd2,   8'd0},  // R4 call inside
    {8'd2,  8'h3C,   8'd0, 8'd255, 8'd1},  // R6 4 blocks
    {8'd2,  8'h40,   8'd0, 8'd255, 8'd0}   // R6 5 blocks
  };

  function automatic string row_req(input int idx);
    case (idx / 2)
      0: return "R3";
      1: return "R5";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] pc, input logic br, input logic call,
                      input logic tb, input logic [31:0] tgt, input logic fl);
    @(negedge clk);
    in_valid = 1'b1; in_pc = pc; in_is_branch = br; in_is_call = call;
    in_taken_back = tb; in_target = tgt; flush = fl;
  endtask

  task automatic idle;
    @(negedge clk);
    in_valid = 1'b0; in_is_branch = 1'b0; in_is_call = 1'b0;
    in_taken_back = 1'b0; flush = 1'b0;
    #1;
  endtask

  task automatic do_flush;
    @(negedge clk);
    in_valid = 1'b0; in_taken_back = 1'b0; flush = 1'b1;
    idle();
  endtask

  // One iteration: body beats then the closing backward branch.
  task automatic iter(input logic [31:0] st, input int n, input int step,
                      input int nbr, input int callpos);
    for (int i = 0; i < n - 1; i++)
      beat(st + 32'(step * i), i < nbr, i == callpos, 1'b0, '0, 1'b0);
    beat(st + 32'(step * (n - 1)), 1'b1, 1'b0, 1'b1, st, 1'b0);
  endtask

  task automatic iters(input logic [31:0] st, input int n, input int step,
                       input int count);
    for (int k = 0; k < count; k++) iter(st, n, step, 0, 255);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "lock", 32'(lock), 0);
    chk("R1", "start", loop_start, 0);
    chk("R1", "end", loop_end, 0);
    @(negedge clk); rst_n = 1'b1;

    // Qualification table.
    for (int r = 0; r < 8; r++) begin
      int n, step, nbr, cp, ex;
      {n, step, nbr, cp, ex} = {24'd0, ROWS[r][39:32], 24'd0, ROWS[r][31:24],
                               24'd0, ROWS[r][23:16], 24'd0, ROWS[r][15:8],
                               24'd0, ROWS[r][7:0]};
      for (int k = 0; k < 66; k++) iter(32'h1000, n, step, nbr, cp);
      idle();
      chk(row_req(r), "lock", 32'(lock), 32'(ex));
      chk("R7", "start", loop_start, ex != 0 ? 32'h1000 : 32'h0);
      chk("R7", "end", loop_end, ex != 0 ? 32'h1000 + 32'(step * (n - 1)) : 32'h0);
      do_flush();
      chk("R10", "lock after flush", 32'(lock), 0);
    end

    // R2: threshold edge.
    iters(32'h2000, 4, 2, 65);
    idle();
    chk("R2", "lock after 64 closings", 32'(lock), 0);
    iters(32'h2000, 4, 2, 1);
    idle();
    chk("R2", "lock after 65 closings", 32'(lock), 1);

    // R9: closing branch falls through.
    beat(32'h2000, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    beat(32'h2006, 1'b1, 1'b0, 1'b0, '0, 1'b0);
    idle();
    chk("R9", "lock after fall-through", 32'(lock), 0);

    // R11: locked, then a beat outside the range.
    iters(32'h2000, 4, 2, 66);
    idle();
    chk("R11", "lock before escape", 32'(lock), 1);
    beat(32'h2002, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    beat(32'h5000, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    idle();
    chk("R11", "lock after escape", 32'(lock), 0);

    // R10: flush while locked.
    iters(32'h2000, 4, 2, 66);
    idle();
    do_flush();
    chk("R10", "lock after flush", 32'(lock), 0);

    // R10: flush in the same cycle as the 65th closing.
    iters(32'h3000, 4, 2, 65);
    beat(32'h3000, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    beat(32'h3002, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    beat(32'h3004, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    beat(32'h3006, 1'b1, 1'b0, 1'b1, 32'h3000, 1'b1);
    idle();
    chk("R10", "flush beats 65th closing", 32'(lock), 0);
    iters(32'h3000, 4, 2, 2);
    idle();
    chk("R10", "count restarted", 32'(lock), 0);
    do_flush();

    // R8: replacing branch restarts the count.
    iters(32'h4000, 5, 2, 40);
    beat(32'h4002, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    beat(32'h4004, 1'b1, 1'b0, 1'b1, 32'h4002, 1'b0);
    beat(32'h4008, 1'b1, 1'b0, 1'b1, 32'h4000, 1'b0);
    iters(32'h4000, 5, 2, 64);
    idle();
    chk("R8", "lock after 64 since replace", 32'(lock), 0);
    iters(32'h4000, 5, 2, 1);
    idle();
    chk("R8", "lock after 65 since replace", 32'(lock), 1);
    chk("R7", "start after replace", loop_start, 32'h4000);
    do_flush();

    // R12: out-of-range beat during counting.
    iters(32'h6000, 3, 4, 30);
    beat(32'h9000, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    iters(32'h6000, 3, 4, 65);
    idle();
    chk("R12", "lock after restart 64", 32'(lock), 0);
    iters(32'h6000, 3, 4, 1);
    idle();
    chk("R12", "lock after restart 65", 32'(lock), 1);

    report();
    $finish;
  end

endmodule